// File: doc/BRIEF.md
# Vector CSR Unit

This block is the control-and-status register slice of a vector-capable core. It serves the five user vector registers: the element start index, the fixed-point saturation flag, the fixed-point rounding mode, the current vector length and the current vector type. It also serves the three floating-point control addresses. One of these is a combined register that packs the accrued exception flags, the FP rounding mode and, when the vector unit is fitted, the two fixed-point fields into one word.

A request carries a 12-bit address, a write enable and write data, and is qualified by `req_valid`. Read data and the illegal flag are combinational and belong to the request of the same cycle. A legal write takes effect on the next rising edge. Two level inputs, `vec_present` and `fp_enabled`, decide which addresses may be touched. The vector length and type can only be loaded through a separate strobe driven by the vector configuration logic. Privilege checks and status dirty tracking live elsewhere.

Top module: `vcsr_unit`

## Requirements
- R1: Address map: 0x001 FP flags, 0x002 FP rounding mode, 0x003 combined FP control, 0x008 vector start, 0x009 saturation, 0x00A fixed-point rounding mode, 0xC20 vector length, 0xC21 vector type. Reads are combinational in the request cycle, and writes are visible from the next cycle.
- R2: While `vec_present` is low, any access to one of the five vector addresses is flagged illegal and changes no state.
- R3: A write request to 0xC20 or 0xC21 is flagged illegal and leaves the stored value unchanged. A read of either address returns the stored value.
- R4: The vector length and type reset to zero. A cycle with `cfg_load` high loads both from `cfg_vl` and `cfg_vtype`, zero-extended to XLEN.
- R5: The combined register holds the flags in bits 4:0, the FP rounding mode in bits 7:5, saturation in bit 8 and the fixed-point rounding mode in bits 10:9, with all higher bits reading zero. A direct write to 0x001 keeps 5 low bits, and a direct write to 0x002 keeps 3 low bits.
- R6: With `vec_present` low, bits 10:8 of a combined-register read are zero.
- R7: A combined-register write always updates the flags and the FP rounding mode. It updates saturation and the fixed-point rounding mode only while `vec_present` is high.
- R8: 0x001 and 0x002 require `fp_enabled`. 0x003 is legal when either `fp_enabled` or `vec_present` is high.
- R9: A direct write to 0x00A keeps 2 low bits, and a direct write to 0x009 keeps 1 low bit. Reads of both are zero-extended.
- R10: The vector start register is XLEN bits wide, fully writable, and resets to zero.
- R11: An address outside the map is flagged illegal and changes no state. Any illegal request returns zero read data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request qualifier |
| req_addr | input | 12 | CSR address |
| req_we | input | 1 | Write request |
| req_wdata | input | XLEN | Write data |
| vec_present | input | 1 | Vector unit fitted and enabled |
| fp_enabled | input | 1 | Floating-point unit enabled |
| cfg_load | input | 1 | Load strobe from vector configuration logic |
| cfg_vl | input | VL_W | New vector length |
| cfg_vtype | input | VTYPE_W | New vector type |
| rsp_rdata | output | XLEN | Read data, zero when illegal or idle |
| rsp_illegal | output | 1 | Access refused |

## Verification
The assertions that check a refused request leaves state untouched assume `cfg_load` is low in that cycle, because the side-load may legitimately change the length and type at any time. The bench therefore never raises `cfg_load` while a request is active, and loads configuration only in request-free cycles. The assertions also take `vec_present` and `fp_enabled` as steady during a request. The bench changes them only between requests, on the falling edge, so each access sees one stable permission pair.

// File: rtl/vcsr_pkg.sv
package vcsr_pkg;

   localparam int ADDR_W = 12;

   localparam logic [ADDR_W-1:0] A_FFLAGS = 12'h001;
   localparam logic [ADDR_W-1:0] A_FRM    = 12'h002;
   localparam logic [ADDR_W-1:0] A_FCSR   = 12'h003;
   localparam logic [ADDR_W-1:0] A_VSTART = 12'h008;
   localparam logic [ADDR_W-1:0] A_VXSAT  = 12'h009;
   localparam logic [ADDR_W-1:0] A_VXRM   = 12'h00A;
   localparam logic [ADDR_W-1:0] A_VL     = 12'hC20;
   localparam logic [ADDR_W-1:0] A_VTYPE  = 12'hC21;

   // combined FP control layout
   localparam int FLG_LSB  = 0;
   localparam int FLG_W    = 5;
   localparam int FRM_LSB  = 5;
   localparam int FRM_W    = 3;
   localparam int SAT_BIT  = 8;
   localparam int FXR_LSB  = 9;
   localparam int FXR_W    = 2;
   localparam int FCSR_TOP = FXR_LSB + FXR_W;

   typedef enum logic [3:0] {
      SEL_NONE,
      SEL_FFLAGS,
      SEL_FRM,
      SEL_FCSR,
      SEL_VSTART,
      SEL_VXSAT,
      SEL_VXRM,
      SEL_VL,
      SEL_VTYPE
   } csr_sel_e;

endpackage

// File: rtl/vcsr_decode.sv
module vcsr_decode
   import vcsr_pkg::*;
(
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic              req_we,
   input  logic              vec_present,
   input  logic              fp_enabled,
   output csr_sel_e          sel,
   output logic              illegal,
   output logic              wr_en
);

   logic deny;

   always_comb begin
      unique case (req_addr)
         A_FFLAGS: sel = SEL_FFLAGS;
         A_FRM:    sel = SEL_FRM;
         A_FCSR:   sel = SEL_FCSR;
         A_VSTART: sel = SEL_VSTART;
         A_VXSAT:  sel = SEL_VXSAT;
         A_VXRM:   sel = SEL_VXRM;
         A_VL:     sel = SEL_VL;
         A_VTYPE:  sel = SEL_VTYPE;
         default:  sel = SEL_NONE;
      endcase
   end

   always_comb begin
      unique case (sel)
         SEL_FFLAGS, SEL_FRM:            deny = !fp_enabled;
         SEL_FCSR:                       deny = !(fp_enabled || vec_present);
         SEL_VSTART, SEL_VXSAT, SEL_VXRM: deny = !vec_present;
         SEL_VL, SEL_VTYPE:              deny = !vec_present || req_we;
         default:                        deny = 1'b1;
      endcase
   end

   assign illegal = req_valid && deny;
   assign wr_en   = req_valid && req_we && !deny;

endmodule

// File: rtl/vcsr_fp_regs.sv
module vcsr_fp_regs
   import vcsr_pkg::*;
(
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  csr_sel_e            sel,
   input  logic [FRM_LSB+FRM_W-1:0] wdata,
   output logic [FLG_W-1:0]    fflags_q,
   output logic [FRM_W-1:0]    frm_q
);

   logic             flg_we;
   logic             frm_we;
   logic [FLG_W-1:0] flg_d;
   logic [FRM_W-1:0] frm_d;

   always_comb begin
      flg_we = 1'b0;
      frm_we = 1'b0;
      flg_d  = wdata[FLG_LSB +: FLG_W];
      frm_d  = wdata[FRM_W-1:0];
      if (wr_en) begin
         unique case (sel)
            SEL_FFLAGS: flg_we = 1'b1;
            SEL_FRM:    frm_we = 1'b1;
            SEL_FCSR: begin
               flg_we = 1'b1;
               frm_we = 1'b1;
               frm_d  = wdata[FRM_LSB +: FRM_W];
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fflags_q <= '0;
         frm_q    <= '0;
      end else begin
         if (flg_we) fflags_q <= flg_d;
         if (frm_we) frm_q    <= frm_d;
      end
   end

endmodule

// File: rtl/vcsr_vec_regs.sv
module vcsr_vec_regs
   import vcsr_pkg::*;
#(
   parameter int XLEN    = 32,
   parameter int VL_W    = 32,
   parameter int VTYPE_W = 32
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  csr_sel_e           sel,
   input  logic [XLEN-1:0]    wdata,
   input  logic               vec_present,
   input  logic               cfg_load,
   input  logic [VL_W-1:0]    cfg_vl,
   input  logic [VTYPE_W-1:0] cfg_vtype,
   output logic [XLEN-1:0]    vstart_q,
   output logic [FXR_W-1:0]   vxrm_q,
   output logic               vxsat_q,
   output logic [XLEN-1:0]    vl_x,
   output logic [XLEN-1:0]    vtype_x
);

   logic [VL_W-1:0]    vl_q;
   logic [VTYPE_W-1:0] vtype_q;
   logic               fcsr_vec_we;
   logic               fxr_we;
   logic               sat_we;
   logic [FXR_W-1:0]   fxr_d;
   logic               sat_d;

   assign fcsr_vec_we = wr_en && (sel == SEL_FCSR) && vec_present;

   always_comb begin
      fxr_we = 1'b0;
      sat_we = 1'b0;
      fxr_d  = wdata[FXR_W-1:0];
      sat_d  = wdata[0];
      if (fcsr_vec_we) begin
         fxr_we = 1'b1;
         sat_we = 1'b1;
         fxr_d  = wdata[FXR_LSB +: FXR_W];
         sat_d  = wdata[SAT_BIT];
      end else if (wr_en && sel == SEL_VXRM) begin
         fxr_we = 1'b1;
      end else if (wr_en && sel == SEL_VXSAT) begin
         sat_we = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vstart_q <= '0;
         vxrm_q   <= '0;
         vxsat_q  <= 1'b0;
      end else begin
         if (wr_en && sel == SEL_VSTART) vstart_q <= wdata;
         if (fxr_we) vxrm_q  <= fxr_d;
         if (sat_we) vxsat_q <= sat_d;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vl_q    <= '0;
         vtype_q <= '0;
      end else if (cfg_load) begin
         vl_q    <= cfg_vl;
         vtype_q <= cfg_vtype;
      end
   end

   generate
      if (VL_W == XLEN) begin : g_vl_full
         assign vl_x = vl_q;
      end else begin : g_vl_ext
         assign vl_x = {{(XLEN-VL_W){1'b0}}, vl_q};
      end
      if (VTYPE_W == XLEN) begin : g_vt_full
         assign vtype_x = vtype_q;
      end else begin : g_vt_ext
         assign vtype_x = {{(XLEN-VTYPE_W){1'b0}}, vtype_q};
      end
   endgenerate

endmodule

// File: rtl/vcsr_unit.sv
module vcsr_unit
   import vcsr_pkg::*;
#(
   parameter int XLEN    = 32,
   parameter int VL_W    = 32,
   parameter int VTYPE_W = 32
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   input  logic [11:0]        req_addr,
   input  logic               req_we,
   input  logic [XLEN-1:0]    req_wdata,
   input  logic               vec_present,
   input  logic               fp_enabled,
   input  logic               cfg_load,
   input  logic [VL_W-1:0]    cfg_vl,
   input  logic [VTYPE_W-1:0] cfg_vtype,
   output logic [XLEN-1:0]    rsp_rdata,
   output logic               rsp_illegal
);

   localparam int PAD_W = XLEN - FCSR_TOP;

   generate
      if (XLEN != 32 && XLEN != 64) begin : g_bad_xlen
         $error("vcsr_unit: XLEN must be 32 or 64");
      end
      if (VL_W < 1 || VL_W > XLEN) begin : g_bad_vl
         $error("vcsr_unit: VL_W must lie in 1..XLEN");
      end
      if (VTYPE_W < 1 || VTYPE_W > XLEN) begin : g_bad_vtype
         $error("vcsr_unit: VTYPE_W must lie in 1..XLEN");
      end
   endgenerate

   csr_sel_e         sel;
   logic             illegal;
   logic             wr_en;
   logic [XLEN-1:0]  vstart_q;
   logic [FXR_W-1:0] vxrm_q;
   logic             vxsat_q;
   logic [XLEN-1:0]  vl_x;
   logic [XLEN-1:0]  vtype_x;
   logic [FLG_W-1:0] fflags_q;
   logic [FRM_W-1:0] frm_q;
   logic [XLEN-1:0]  fcsr_view;
   logic [XLEN-1:0]  mux_q;

   vcsr_decode u_dec (
      .req_valid   (req_valid),
      .req_addr    (req_addr),
      .req_we      (req_we),
      .vec_present (vec_present),
      .fp_enabled  (fp_enabled),
      .sel         (sel),
      .illegal     (illegal),
      .wr_en       (wr_en)
   );

   vcsr_fp_regs u_fp (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .sel      (sel),
      .wdata    (req_wdata[FRM_LSB+FRM_W-1:0]),
      .fflags_q (fflags_q),
      .frm_q    (frm_q)
   );

   vcsr_vec_regs #(
      .XLEN    (XLEN),
      .VL_W    (VL_W),
      .VTYPE_W (VTYPE_W)
   ) u_vec (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_en       (wr_en),
      .sel         (sel),
      .wdata       (req_wdata),
      .vec_present (vec_present),
      .cfg_load    (cfg_load),
      .cfg_vl      (cfg_vl),
      .cfg_vtype   (cfg_vtype),
      .vstart_q    (vstart_q),
      .vxrm_q      (vxrm_q),
      .vxsat_q     (vxsat_q),
      .vl_x        (vl_x),
      .vtype_x     (vtype_x)
   );

   // vector fields appear in the combined view only with the vector unit
   assign fcsr_view = {{PAD_W{1'b0}},
                       vxrm_q  & {FXR_W{vec_present}},
                       vxsat_q & vec_present,
                       frm_q,
                       fflags_q};

   always_comb begin
      unique case (sel)
         SEL_FFLAGS: mux_q = {{(XLEN-FLG_W){1'b0}}, fflags_q};
         SEL_FRM:    mux_q = {{(XLEN-FRM_W){1'b0}}, frm_q};
         SEL_FCSR:   mux_q = fcsr_view;
         SEL_VSTART: mux_q = vstart_q;
         SEL_VXSAT:  mux_q = {{(XLEN-1){1'b0}}, vxsat_q};
         SEL_VXRM:   mux_q = {{(XLEN-FXR_W){1'b0}}, vxrm_q};
         SEL_VL:     mux_q = vl_x;
         SEL_VTYPE:  mux_q = vtype_x;
         default:    mux_q = '0;
      endcase
   end

   assign rsp_rdata   = (req_valid && !illegal) ? mux_q : '0;
   assign rsp_illegal = illegal;

endmodule

// File: rtl/vcsr_unit_chk.sv
module vcsr_unit_chk #(
   parameter int XLEN = 32,
   parameter int VL_W = 32
)(
   input logic            clk,
   input logic            rst_n,
   input logic            req_valid,
   input logic [11:0]     req_addr,
   input logic            req_we,
   input logic            vec_present,
   input logic            fp_enabled,
   input logic            cfg_load,
   input logic [VL_W-1:0] cfg_vl,
   input logic [XLEN-1:0] rsp_rdata,
   input logic            rsp_illegal,
   input logic [XLEN-1:0] vstart_v,
   input logic [1:0]      vxrm_v,
   input logic            vxsat_v,
   input logic [XLEN-1:0] vl_v,
   input logic [XLEN-1:0] vtype_v,
   input logic [4:0]      fflags_v,
   input logic [2:0]      frm_v
);

   logic is_vec;
   logic is_known;
   assign is_vec = (req_addr == 12'h008) || (req_addr == 12'h009) ||
                   (req_addr == 12'h00A) || (req_addr == 12'hC20) ||
                   (req_addr == 12'hC21);
   assign is_known = is_vec || (req_addr == 12'h001) ||
                     (req_addr == 12'h002) || (req_addr == 12'h003);

   // R2
   vec_absent_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && is_vec && !vec_present |-> rsp_illegal);

   // R3
   cfg_ro_illegal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_we && (req_addr == 12'hC20 || req_addr == 12'hC21)
      |-> rsp_illegal);

   // R3
   cfg_ro_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_we && (req_addr == 12'hC20 || req_addr == 12'hC21) && !cfg_load
      |=> $stable(vl_v) && $stable(vtype_v));

   // R4
   cfg_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_load |=> vl_v[VL_W-1:0] == $past(cfg_vl));

   // R6
   fcsr_novec_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_addr == 12'h003 && !vec_present |-> rsp_rdata[10:8] == 3'b000);

   // R8
   fcsr_relax_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_addr == 12'h003 && (vec_present || fp_enabled) |-> !rsp_illegal);

   // R8
   fp_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && (req_addr == 12'h001 || req_addr == 12'h002) && !fp_enabled
      |-> rsp_illegal);

   // R9
   vxrm_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_addr == 12'h00A && !rsp_illegal |-> rsp_rdata[XLEN-1:2] == '0);

   // R11
   unknown_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && !is_known |-> rsp_illegal);

   // R11
   illegal_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_illegal |-> rsp_rdata == '0);

   // R11
   illegal_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_illegal && !cfg_load |=> $stable(vstart_v) && $stable(vxrm_v) &&
      $stable(vxsat_v) && $stable(fflags_v) && $stable(frm_v) &&
      $stable(vl_v) && $stable(vtype_v));

endmodule

bind vcsr_unit vcsr_unit_chk #(
   .XLEN (XLEN),
   .VL_W (VL_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .req_valid   (req_valid),
   .req_addr    (req_addr),
   .req_we      (req_we),
   .vec_present (vec_present),
   .fp_enabled  (fp_enabled),
   .cfg_load    (cfg_load),
   .cfg_vl      (cfg_vl),
   .rsp_rdata   (rsp_rdata),
   .rsp_illegal (rsp_illegal),
   .vstart_v    (vstart_q),
   .vxrm_v      (vxrm_q),
   .vxsat_v     (vxsat_q),
   .vl_v        (vl_x),
   .vtype_v     (vtype_x),
   .fflags_v    (fflags_q),
   .frm_v       (frm_q)
);

// File: tb/vcsr_unit_tb.sv
`timescale 1ns/1ps
module vcsr_unit_tb;

   localparam int XLEN = 32;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            req_valid = 1'b0;
   logic [11:0]     req_addr = '0;
   logic            req_we = 1'b0;
   logic [XLEN-1:0] req_wdata = '0;
   logic            vec_present = 1'b1;
   logic            fp_enabled = 1'b1;
   logic            cfg_load = 1'b0;
   logic [31:0]     cfg_vl = '0;
   logic [31:0]     cfg_vtype = '0;
   logic [XLEN-1:0] rsp_rdata;
   logic            rsp_illegal;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   vcsr_unit u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
      .req_we(req_we), .req_wdata(req_wdata), .vec_present(vec_present),
      .fp_enabled(fp_enabled), .cfg_load(cfg_load), .cfg_vl(cfg_vl),
      .cfg_vtype(cfg_vtype), .rsp_rdata(rsp_rdata), .rsp_illegal(rsp_illegal)
   );

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic acc(input logic [11:0] a, input logic we, input logic [31:0] d,
                      output logic [31:0] rd, output logic ill);
      @(negedge clk);
      req_valid = 1'b1; req_addr = a; req_we = we; req_wdata = d;
      #1;
      rd  = rsp_rdata;
      ill = rsp_illegal;
      @(posedge clk);
      #1;
      req_valid = 1'b0; req_we = 1'b0;
   endtask

   task automatic rd_exp(input string req, input logic [11:0] a,
                         input logic [31:0] exp, input logic exp_ill);
      logic [31:0] r; logic i;
      acc(a, 1'b0, '0, r, i);
      chk(req, $sformatf("read %h data", a), r, exp);
      chk(req, $sformatf("read %h illegal", a), {31'd0, i}, {31'd0, exp_ill});
   endtask

   task automatic wr_exp(input string req, input logic [11:0] a,
                         input logic [31:0] d, input logic exp_ill);
      logic [31:0] r; logic i;
      acc(a, 1'b1, d, r, i);
      chk(req, $sformatf("write %h illegal", a), {31'd0, i}, {31'd0, exp_ill});
   endtask

   task automatic set_perm(input logic v, input logic f);
      @(negedge clk);
      vec_present = v; fp_enabled = f;
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      rd_exp("R10", 12'h008, 32'h0, 1'b0);
      rd_exp("R4",  12'hC20, 32'h0, 1'b0);
      rd_exp("R4",  12'hC21, 32'h0, 1'b0);
      rd_exp("R5",  12'h003, 32'h0, 1'b0);
      rd_exp("R9",  12'h00A, 32'h0, 1'b0);
   endtask

   task automatic t_vstart();
      wr_exp("R10", 12'h008, 32'hDEADBEEF, 1'b0);
      rd_exp("R10", 12'h008, 32'hDEADBEEF, 1'b0);
      wr_exp("R1",  12'h008, 32'h0000_0010, 1'b0);
      rd_exp("R1",  12'h008, 32'h0000_0010, 1'b0);
   endtask

   task automatic t_fixed_point();
      wr_exp("R9", 12'h00A, 32'hFFFF_FFFE, 1'b0);
      rd_exp("R9", 12'h00A, 32'h2, 1'b0);
      wr_exp("R9", 12'h009, 32'hFFFF_FFFE, 1'b0);
      rd_exp("R9", 12'h009, 32'h0, 1'b0);
      wr_exp("R9", 12'h009, 32'h3, 1'b0);
      rd_exp("R9", 12'h009, 32'h1, 1'b0);
   endtask

   task automatic t_cfg();
      @(negedge clk);
      cfg_load = 1'b1; cfg_vl = 32'd17; cfg_vtype = 32'h8000_0043;
      @(posedge clk);
      #1 cfg_load = 1'b0;
      rd_exp("R4", 12'hC20, 32'd17, 1'b0);
      rd_exp("R4", 12'hC21, 32'h8000_0043, 1'b0);
      wr_exp("R3", 12'hC20, 32'd99, 1'b1);
      wr_exp("R3", 12'hC21, 32'h1, 1'b1);
      rd_exp("R3", 12'hC20, 32'd17, 1'b0);
      rd_exp("R3", 12'hC21, 32'h8000_0043, 1'b0);
   endtask

   task automatic t_fcsr_vec();
      // vxrm=2 @10:9, vxsat=1 @8, frm=5 @7:5, flags=5 @4:0 -> 0x5A5
      wr_exp("R7", 12'h003, 32'hFFFF_F5A5, 1'b0);
      rd_exp("R5", 12'h003, 32'h0000_05A5, 1'b0);
      rd_exp("R5", 12'h00A, 32'h2, 1'b0);
      rd_exp("R5", 12'h009, 32'h1, 1'b0);
      rd_exp("R5", 12'h002, 32'h5, 1'b0);
      rd_exp("R5", 12'h001, 32'h5, 1'b0);
      wr_exp("R5", 12'h002, 32'hFF, 1'b0);
      rd_exp("R5", 12'h002, 32'h7, 1'b0);
      wr_exp("R5", 12'h001, 32'hFFFF_FFE3, 1'b0);
      rd_exp("R5", 12'h001, 32'h03, 1'b0);
      rd_exp("R5", 12'h003, 32'h0000_05E3, 1'b0);
   endtask

   task automatic t_fcsr_novec();
      set_perm(1'b0, 1'b1);
      rd_exp("R6", 12'h003, 32'h0000_00E3, 1'b0);
      wr_exp("R7", 12'h003, 32'h0000_0042, 1'b0);
      rd_exp("R7", 12'h003, 32'h0000_0042, 1'b0);
      set_perm(1'b1, 1'b1);
      rd_exp("R7", 12'h00A, 32'h2, 1'b0);
      rd_exp("R7", 12'h009, 32'h1, 1'b0);
      rd_exp("R7", 12'h003, 32'h0000_0542, 1'b0);
   endtask

   task automatic t_vec_absent();
      set_perm(1'b0, 1'b1);
      rd_exp("R2", 12'h008, 32'h0, 1'b1);
      rd_exp("R2", 12'h009, 32'h0, 1'b1);
      rd_exp("R2", 12'h00A, 32'h0, 1'b1);
      rd_exp("R2", 12'hC20, 32'h0, 1'b1);
      rd_exp("R2", 12'hC21, 32'h0, 1'b1);
      wr_exp("R2", 12'h008, 32'h1234, 1'b1);
      wr_exp("R2", 12'h00A, 32'h1, 1'b1);
      set_perm(1'b1, 1'b1);
      rd_exp("R2", 12'h008, 32'h0000_0010, 1'b0);
      rd_exp("R2", 12'h00A, 32'h2, 1'b0);
   endtask

   task automatic t_fp_gate();
      set_perm(1'b1, 1'b0);
      rd_exp("R8", 12'h001, 32'h0, 1'b1);
      rd_exp("R8", 12'h002, 32'h0, 1'b1);
      wr_exp("R8", 12'h002, 32'h1, 1'b1);
      rd_exp("R8", 12'h003, 32'h0000_0542, 1'b0);
      set_perm(1'b0, 1'b0);
      rd_exp("R8", 12'h003, 32'h0, 1'b1);
      set_perm(1'b1, 1'b1);
      rd_exp("R8", 12'h002, 32'h2, 1'b0);
   endtask

   task automatic t_unknown();
      wr_exp("R11", 12'h004, 32'hFFFF_FFFF, 1'b1);
      wr_exp("R11", 12'hC22, 32'hFFFF_FFFF, 1'b1);
      wr_exp("R11", 12'h108, 32'hFFFF_FFFF, 1'b1);
      rd_exp("R11", 12'h000, 32'h0, 1'b1);
      rd_exp("R11", 12'h008, 32'h0000_0010, 1'b0);
      rd_exp("R11", 12'h003, 32'h0000_0542, 1'b0);
      rd_exp("R11", 12'hC20, 32'd17, 1'b0);
   endtask

   task automatic run_all();
      t_reset();
      t_vstart();
      t_fixed_point();
      t_cfg();
      t_fcsr_vec();
      t_fcsr_novec();
      t_vec_absent();
      t_fp_gate();
      t_unknown();
   endtask

   initial begin
      fork
         run_all();
         begin
            repeat (20000) @(posedge clk);
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      disable fork;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule